// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block keeps the status word of a small core that runs in a supervisor mode. It also performs the register updates for trap entry and trap return. The core passes in the PC of the instruction it is retiring, a synchronous exception request with its cause code, a return request, and a set of level-sensitive interrupt lines. From these the block decides when to redirect fetch and where to send it. On trap entry it records the cause and the faulting PC, and it pushes the privilege and interrupt-enable bits onto a one-deep stack held in the status word. A return request pops that stack and sends fetch back to the saved PC.

Software reaches four registers through a CSR-style port: status, saved PC, trap vector and cause. The port is combinational. In any cycle that asserts read or write it shows the value the register held before that cycle, so a read-modify-write instruction gets the old value while the new one is written at the clock edge. An access to any other address is flagged as illegal and enters a trap in its own right.

Status layout: bit 0 supervisor, bit 1 previous supervisor, bit 2 interrupt enable, bit 3 previous enable, bit 4 supervisor 64-bit mode, bit 5 user 64-bit mode, bits 15:8 interrupt mask, bits 23:16 interrupt pending. All other bits read as zero. CSR addresses: 0 status, 1 saved PC, 2 trap vector, 3 cause, 4 to 7 unimplemented.

Top module: `trap_ctrl_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `redirect_valid_o` is 1 with `redirect_pc_o` = 0x2000. Status then reads 0x11 (supervisor and supervisor-64 only), and saved PC, vector and cause read 0.
- R2: No interrupt is taken unless the status enable bit (bit 2) is 1 and at least one bit of pending AND mask is 1.
- R3: Among the eligible interrupts, the one with the lowest index is taken.
- R4: An interrupt's cause is its index with bit 63 also set when status bit 4 is 1, or with bit 31 also set when status bit 4 is 0.
- R5: On trap entry, previous-supervisor takes the old supervisor bit and previous-enable takes the old enable bit. Supervisor becomes 1 and enable becomes 0.
- R6: On trap entry, cause takes the trap cause and saved PC takes `pc_i`. In the next cycle `redirect_valid_o` is 1 for that one cycle only, with `redirect_pc_o` equal to the vector register.
- R7: Every write to the vector register (address 2) stores bits 1:0 as zero.
- R8: A status write cannot change bits 23:16. That field shows `irq_i` as sampled at the previous clock edge.
- R9: A read or write of addresses 4 to 7 raises `csr_illegal_o` in the same cycle. At the next edge it enters a trap with cause 2, and no register takes the write data.
- R10: When an exception request falls in a cycle where an interrupt is also eligible, the exception cause is recorded. Any CSR write in a cycle that enters a trap is discarded.
- R11: In a write cycle, `csr_rdata_o` shows the register's value from before the write.
- R12: A return request (with no trap in the same cycle) sets supervisor from previous-supervisor and enable from previous-enable. The next cycle carries a one-cycle redirect to the saved PC.
- R13: The cause register (address 3) is read-only: writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 8 | Interrupt request lines, index 0 most urgent |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | 64 | Cause code of the exception |
| ret_req_i | input | 1 | Return-from-trap request |
| pc_i | input | 64 | PC of the instruction being retired |
| csr_re_i | input | 1 | CSR read strobe |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 3 | CSR address |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | Register value before this cycle |
| csr_illegal_o | output | 1 | Access to an unimplemented address |
| redirect_valid_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | 64 | Redirect target |
| epc_o | output | 64 | Saved exception PC |
| cause_o | output | 64 | Cause register |

## Verification
Trap entry can land in the same cycle as a CSR write, and an exception request can land in the same cycle as an eligible interrupt. The bench first arms an interrupt by setting the enable and mask bits. It then drives an exception, together with a write to the vector register, into the cycle in which that interrupt would be taken. It judges the result by the recorded cause, by the saved PC, and by reading back the unchanged vector. The return path is checked with a second interrupt raised in the same cycle as the return request. That interrupt must be taken only after the return has restored the enable bit.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;

    localparam int XLEN         = 64;
    localparam int IRQ_N        = 8;
    localparam int IRQ_IW       = $clog2(IRQ_N);
    localparam int CSR_AW       = 3;
    localparam int HI_RSV_W     = XLEN - 2 * IRQ_N - 8;
    localparam logic [XLEN-1:0] BOOT_PC      = 64'h2000;
    localparam logic [XLEN-1:0] ILLEGAL_CODE = 64'd2;

    typedef struct packed {
        logic [HI_RSV_W-1:0] rsv_hi;
        logic [IRQ_N-1:0]    ip;
        logic [IRQ_N-1:0]    im;
        logic [1:0]          rsv_lo;
        logic                u64;
        logic                s64;
        logic                pei;
        logic                ei;
        logic                ps;
        logic                s;
    } status_t;

    typedef enum logic [CSR_AW-1:0] {
        SEL_STAT  = 3'd0,
        SEL_EPC   = 3'd1,
        SEL_VEC   = 3'd2,
        SEL_CAUSE = 3'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        TK_NONE,
        TK_EXC,
        TK_ILL,
        TK_IRQ
    } trap_kind_e;

    function automatic status_t boot_status();
        status_t v;
        v     = '0;
        v.s   = 1'b1;
        v.s64 = 1'b1;
        return v;
    endfunction

    function automatic status_t sw_write_mask(input logic wide_ok);
        status_t m;
        m     = '0;
        m.s   = 1'b1;
        m.ps  = 1'b1;
        m.ei  = 1'b1;
        m.pei = 1'b1;
        m.s64 = wide_ok;
        m.u64 = wide_ok;
        m.im  = '1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] irq_cause(input logic [IRQ_IW-1:0] idx,
                                                  input logic wide);
        logic [XLEN-1:0] c;
        c = '0;
        c[IRQ_IW-1:0] = idx;
        if (wide) c[XLEN-1] = 1'b1;
        else      c[31]     = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/trap_irq_sel.sv
module trap_irq_sel
    import trapctl_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  mask,
    input  logic          gie,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] elig;
    logic [N-1:0] grant;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_gate
            assign elig[g] = pend[g] & mask[g] & gie;
        end
    endgenerate

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                idx    = IW'(i);
            end
        end
    end

    assign any = |elig;

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~(pend & mask)) == '0));

    // R2
    gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> (gie && ((pend & mask) != '0)));

endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
    import trapctl_pkg::*;
#(
    parameter bit HAS_WIDE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] irq_i,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             trap_take,
    input  logic             ret_take,
    output status_t          status_o
);
    status_t sr_q;
    status_t sr_d;
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] ipmask;

    generate
        if (HAS_WIDE) begin : g_wide
            assign wmask = sw_write_mask(1'b1);
        end else begin : g_narrow
            assign wmask = sw_write_mask(1'b0);
        end
    endgenerate

    always_comb begin
        status_t pm;
        pm    = '0;
        pm.ip = '1;
        ipmask = pm;
    end

    always_comb begin
        sr_d = sr_q;
        if (trap_take) begin
            sr_d.ps  = sr_q.s;
            sr_d.pei = sr_q.ei;
            sr_d.s   = 1'b1;
            sr_d.ei  = 1'b0;
        end else if (ret_take) begin
            sr_d.s  = sr_q.ps;
            sr_d.ei = sr_q.pei;
        end else if (wr_en) begin
            sr_d = (wr_data & wmask) | (sr_q & ipmask);
        end
        sr_d.ip = irq_i;
    end

    always_ff @(posedge clk) begin
        if (rst) sr_q <= boot_status();
        else     sr_q <= sr_d;
    end

    assign status_o = sr_q;

    // R5
    trap_stack_chk: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (sr_q.s && !sr_q.ei && sr_q.ps == $past(sr_q.s)
                       && sr_q.pei == $past(sr_q.ei)));

    // R12
    ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
        ret_take |=> (sr_q.s == $past(sr_q.ps) && sr_q.ei == $past(sr_q.pei)));

    // R8
    ip_hw_only_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sr_q.ip == $past(irq_i)));

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trapctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] addr,
    input  logic              re,
    input  logic              we,
    input  logic [XLEN-1:0]   wdata,
    input  logic              commit_ok,
    input  status_t           status_i,
    input  logic              trap_take,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [XLEN-1:0]   pc_i,
    output logic [XLEN-1:0]   rdata,
    output logic              illegal,
    output logic              stat_we,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   vec_o,
    output logic [XLEN-1:0]   cause_o
);
    logic [XLEN-1:0] epc_q, vec_q, cause_q;
    logic            known;
    csr_sel_e        sel;

    assign sel = csr_sel_e'(addr);

    always_comb begin
        known = 1'b1;
        rdata = '0;
        case (sel)
            SEL_STAT:  rdata = status_i;
            SEL_EPC:   rdata = epc_q;
            SEL_VEC:   rdata = vec_q;
            SEL_CAUSE: rdata = cause_q;
            default:   known = 1'b0;
        endcase
    end

    assign illegal = (re | we) & ~known;
    assign stat_we = we & commit_ok & (sel == SEL_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            vec_q   <= '0;
            cause_q <= '0;
        end else if (trap_take) begin
            cause_q <= trap_cause;
            epc_q   <= pc_i;
        end else if (we && commit_ok) begin
            case (sel)
                SEL_EPC: epc_q <= wdata;
                SEL_VEC: vec_q <= {wdata[XLEN-1:2], 2'b00};
                default: ;
            endcase
        end
    end

    assign epc_o   = epc_q;
    assign vec_o   = vec_q;
    assign cause_o = cause_q;

    // R7
    vec_align_chk: assert property (@(posedge clk) disable iff (rst)
        vec_q[1:0] == 2'b00);

    // R13
    cause_ro_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_take |=> $stable(cause_q));

    // R6
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (epc_q == $past(pc_i) && cause_q == $past(trap_cause)));

endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
    import trapctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IRQ_N-1:0]  irq_i,
    input  logic              exc_req_i,
    input  logic [XLEN-1:0]   exc_cause_i,
    input  logic              ret_req_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              csr_re_i,
    input  logic              csr_we_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              csr_illegal_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   cause_o
);
    status_t          status;
    logic             irq_any;
    logic [IRQ_IW-1:0] irq_idx;
    trap_kind_e       kind;
    logic [XLEN-1:0]  trap_cause;
    logic             trap_take, ret_take, commit_ok, stat_we, illegal;
    logic [XLEN-1:0]  vec;
    logic             rv_q;
    logic [XLEN-1:0]  rpc_q;

    trap_irq_sel #(.N(IRQ_N)) u_sel (
        .clk  (clk),
        .rst  (rst),
        .pend (status.ip),
        .mask (status.im),
        .gie  (status.ei),
        .any  (irq_any),
        .idx  (irq_idx)
    );

    always_comb begin
        if (exc_req_i)    kind = TK_EXC;
        else if (illegal) kind = TK_ILL;
        else if (irq_any) kind = TK_IRQ;
        else              kind = TK_NONE;
        case (kind)
            TK_EXC:  trap_cause = exc_cause_i;
            TK_ILL:  trap_cause = ILLEGAL_CODE;
            TK_IRQ:  trap_cause = irq_cause(irq_idx, status.s64);
            default: trap_cause = '0;
        endcase
    end

    assign trap_take = (kind != TK_NONE);
    assign ret_take  = ret_req_i & ~trap_take;
    assign commit_ok = ~trap_take & ~ret_req_i;

    trap_status_reg #(.HAS_WIDE(1'b1)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .irq_i     (irq_i),
        .wr_en     (stat_we),
        .wr_data   (csr_wdata_i),
        .trap_take (trap_take),
        .ret_take  (ret_take),
        .status_o  (status)
    );

    trap_csr_file u_csr (
        .clk        (clk),
        .rst        (rst),
        .addr       (csr_addr_i),
        .re         (csr_re_i),
        .we         (csr_we_i),
        .wdata      (csr_wdata_i),
        .commit_ok  (commit_ok),
        .status_i   (status),
        .trap_take  (trap_take),
        .trap_cause (trap_cause),
        .pc_i       (pc_i),
        .rdata      (csr_rdata_o),
        .illegal    (illegal),
        .stat_we    (stat_we),
        .epc_o      (epc_o),
        .vec_o      (vec),
        .cause_o    (cause_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q  <= 1'b1;
            rpc_q <= BOOT_PC;
        end else begin
            rv_q <= trap_take | ret_take;
            if (trap_take)     rpc_q <= vec;
            else if (ret_take) rpc_q <= epc_o;
        end
    end

    assign csr_illegal_o    = illegal;
    assign redirect_valid_o = rv_q;
    assign redirect_pc_o    = rpc_q;

    // R6
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trap_take |=> (redirect_valid_o && redirect_pc_o == $past(vec)));

    // R10
    exc_first_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req_i |=> (cause_o == $past(exc_cause_i)));

    // R9
    illegal_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal && !exc_req_i) |=> (cause_o == ILLEGAL_CODE && redirect_valid_o));

    // R12
    ret_target_chk: assert property (@(posedge clk) disable iff (rst)
        ret_take |=> (redirect_valid_o && redirect_pc_o == $past(epc_o)));

endmodule

// File: tb/sim_trap_ctrl_unit.sv
module sim_trap_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  irq_i = '0;
    logic        exc_req_i = 1'b0;
    logic [63:0] exc_cause_i = '0;
    logic        ret_req_i = 1'b0;
    logic [63:0] pc_i = '0;
    logic        csr_re_i = 1'b0;
    logic        csr_we_i = 1'b0;
    logic [2:0]  csr_addr_i = '0;
    logic [63:0] csr_wdata_i = '0;
    logic [63:0] csr_rdata_o;
    logic        csr_illegal_o;
    logic        redirect_valid_o;
    logic [63:0] redirect_pc_o;
    logic [63:0] epc_o;
    logic [63:0] cause_o;

    int nvec = 0;
    int nbad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    trap_ctrl_unit u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [2:0] a, input logic [63:0] d, output logic [63:0] old);
        csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
        #1 old = csr_rdata_o;
        @(negedge clk);
        csr_we_i = 1'b0;
    endtask

    task automatic csr_rd(input logic [2:0] a, output logic [63:0] v);
        csr_re_i = 1'b1; csr_addr_i = a;
        #1 v = csr_rdata_o;
        chk("R9 legal address not flagged", {63'd0, csr_illegal_o}, 64'd0);
        csr_re_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 boot redirect valid", {63'd0, redirect_valid_o}, 64'd1);
        chk("R1 boot redirect pc", redirect_pc_o, 64'h2000);
        @(negedge clk);
        #1 chk("R1 boot redirect drops", {63'd0, redirect_valid_o}, 64'd0);
        csr_rd(3'd0, v); chk("R1 status", v, 64'h11);
        csr_rd(3'd1, v); chk("R1 epc", v, 64'h0);
        csr_rd(3'd2, v); chk("R1 vector", v, 64'h0);
        csr_rd(3'd3, v); chk("R1 cause", v, 64'h0);
    endtask

    task automatic t_csr_basic();
        logic [63:0] v, old;
        csr_wr(3'd2, 64'h1003, old);
        csr_rd(3'd2, v); chk("R7 vector low bits cleared", v, 64'h1000);
        csr_wr(3'd1, 64'hAAAA, old); chk("R11 old epc", old, 64'h0);
        csr_wr(3'd1, 64'h5555, old); chk("R11 old epc second", old, 64'hAAAA);
        csr_rd(3'd1, v); chk("R11 new epc", v, 64'h5555);
        csr_wr(3'd3, 64'h77, old);
        csr_rd(3'd3, v); chk("R13 cause unchanged", v, 64'h0);
    endtask

    task automatic t_ip_protect();
        logic [63:0] v, old;
        irq_i = 8'h00;
        @(negedge clk);
        csr_wr(3'd0, 64'h00FF_0011, old);
        csr_rd(3'd0, v); chk("R8 pending field not writable", v, 64'h11);
        irq_i = 8'h05;
        @(negedge clk);
        csr_rd(3'd0, v); chk("R8 pending follows lines", v, 64'h0005_0011);
        chk("R2 masked, no trap", {63'd0, redirect_valid_o}, 64'd0);
    endtask

    task automatic t_irq_gate();
        logic [63:0] v, old;
        csr_wr(3'd0, 64'h0000_FF11, old);
        @(negedge clk);
        #1 chk("R2 enable off, no trap", {63'd0, redirect_valid_o}, 64'd0);
        @(negedge clk);
        #1 chk("R2 enable off, still none", {63'd0, redirect_valid_o}, 64'd0);
        csr_rd(3'd0, v); chk("R2 status", v, 64'h0005_FF11);
    endtask

    task automatic t_irq_take();
        logic [63:0] v, old;
        pc_i = 64'h4000;
        csr_wr(3'd0, 64'h0000_FF15, old);
        #1 chk("R2 not in enabling cycle", {63'd0, redirect_valid_o}, 64'd0);
        @(negedge clk);
        #1;
        chk("R6 redirect valid", {63'd0, redirect_valid_o}, 64'd1);
        chk("R6 redirect to vector", redirect_pc_o, 64'h1000);
        chk("R3 R4 lowest index, wide cause", cause_o, 64'h8000_0000_0000_0000);
        chk("R6 epc", epc_o, 64'h4000);
        csr_rd(3'd0, v); chk("R5 stacked status", v, 64'h0005_FF1B);
        @(negedge clk);
        #1 chk("R6 one-cycle pulse", {63'd0, redirect_valid_o}, 64'd0);
    endtask

    task automatic t_ret();
        logic [63:0] v;
        ret_req_i = 1'b1; irq_i = 8'h0C;
        @(negedge clk);
        ret_req_i = 1'b0; pc_i = 64'h5000;
        #1;
        chk("R12 redirect valid", {63'd0, redirect_valid_o}, 64'd1);
        chk("R12 redirect to epc", redirect_pc_o, 64'h4000);
        csr_rd(3'd0, v); chk("R12 restored status", v, 64'h000C_FF1F);
        @(negedge clk);
        #1;
        chk("R3 next interrupt taken", {63'd0, redirect_valid_o}, 64'd1);
        chk("R3 index 2 wins", cause_o, 64'h8000_0000_0000_0002);
        chk("R6 epc of second trap", epc_o, 64'h5000);
    endtask

    task automatic t_mode32();
        logic [63:0] old;
        csr_wr(3'd0, 64'h0000_FF05, old);
        @(negedge clk);
        #1;
        chk("R4 narrow mode trap", {63'd0, redirect_valid_o}, 64'd1);
        chk("R4 narrow cause", cause_o, 64'h0000_0000_8000_0002);
    endtask

    task automatic t_collide();
        logic [63:0] v, old;
        csr_wr(3'd0, 64'h0000_FF15, old);
        exc_req_i = 1'b1; exc_cause_i = 64'd5; pc_i = 64'h6000;
        csr_we_i = 1'b1; csr_addr_i = 3'd2; csr_wdata_i = 64'h2224;
        @(negedge clk);
        exc_req_i = 1'b0; csr_we_i = 1'b0;
        #1;
        chk("R10 exception cause wins", cause_o, 64'd5);
        chk("R10 epc", epc_o, 64'h6000);
        chk("R10 redirect", redirect_pc_o, 64'h1000);
        csr_rd(3'd2, v); chk("R10 write dropped", v, 64'h1000);
    endtask

    task automatic t_illegal();
        logic [63:0] v, old;
        irq_i = 8'h00;
        csr_wr(3'd0, 64'h0000_0014, old);
        csr_rd(3'd0, v); chk("R5 pre-trap status", v, 64'h14);
        pc_i = 64'h7000;
        csr_re_i = 1'b1; csr_addr_i = 3'd5;
        #1 chk("R9 illegal flag", {63'd0, csr_illegal_o}, 64'd1);
        @(negedge clk);
        csr_re_i = 1'b0;
        #1;
        chk("R9 trap taken", {63'd0, redirect_valid_o}, 64'd1);
        chk("R9 cause", cause_o, 64'd2);
        chk("R9 epc", epc_o, 64'h7000);
        csr_rd(3'd0, v); chk("R5 user-mode stacking", v, 64'h19);
    endtask

    initial begin
        t_reset();
        t_csr_basic();
        t_ip_protect();
        t_irq_gate();
        t_irq_take();
        t_ret();
        t_mode32();
        t_collide();
        t_illegal();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                nbad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule